// File: doc/BRIEF.md
# Mode-switching shared memory model

This block models a shared memory that serves several processors over a small set of word addresses. Instructions arrive one at a time, in order, on a valid/ready input. Each carries a read/write flag, the issuing processor's index, an address and, for a write, a data word. Every accepted instruction produces exactly one response carrying the same flag, processor index and address, plus a data word. The block is intended as a stimulus target for consistency checkers: it behaves like a plain serial memory unless its first instructions match one particular pattern.

Two storage images are kept side by side from reset. The shared image is a single array indexed by address alone. The split image holds one private array per processor. Each accepted instruction is applied to both images. A mode decision is latched from the opening window of NUM_PROC·NUM_ADDR instructions. Split mode is chosen only when that window consists of one write from every processor to every address. Anything else selects shared mode, and the decision is taken on the first instruction that makes the split outcome impossible. Until the mode is known, the responses of both images are parked in paired buffer slots. Once it is known, the chosen image's responses drain in instruction order.

Top module: `mode_switch_mem`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every word of both images reads as zero.
- R2: The window is the first NUM_PROC·NUM_ADDR accepted instructions. Split mode is chosen only if these are all writes and no (processor, address) pair repeats, so every pair is written exactly once.
- R3: Shared mode is latched on the first read, or the first repeated (processor, address) write, inside the window, without waiting for the window to fill. Responses held so far become visible on the next cycle.
- R4: out_valid stays 0 while the mode is undecided.
- R5: In shared mode the processor index is ignored. A read returns the last value written to that address by any processor.
- R6: In split mode a read returns the last value written by the same processor to that address. A write changes only the issuing processor's copy.
- R7: A response carries out_write equal to the instruction's write flag, and the instruction's processor and address. out_data is the written word for a write and the stored word before the access for a read.
- R8: Responses leave in the order in which their instructions were accepted.
- R9: The buffer holds NUM_PROC·NUM_ADDR response pairs. When it is full, in_ready is 0. While out_ready is 0, a presented response stays stable and none is lost.
- R10: Once latched, the mode does not change until reset.
- R11: Both images are updated from reset onward, so the values written inside the window are readable afterwards in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when high with in_valid |
| in_write | input | 1 | 1 = write, 0 = read |
| in_proc | input | PW | Issuing processor index, below NUM_PROC |
| in_addr | input | AW | Word address, below NUM_ADDR |
| in_data | input | DATA_W | Write data (ignored for reads) |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response this cycle |
| out_write | output | 1 | Response kind, 1 = write |
| out_proc | output | PW | Processor index of the response |
| out_addr | output | AW | Address of the response |
| out_data | output | DATA_W | Returned or written data word |

## Verification
The assertions assume that every presented instruction names a processor below NUM_PROC and an address below NUM_ADDR. They also assume that the consumer only ever withholds out_ready and never needs a response to be retracted. The bench keeps within this by issuing only legal indices at the default three processors and two addresses. It holds out_ready low while it fills the buffer, then raises it one response at a time and compares each response against values worked out by hand for both images.

// File: rtl/msm_pkg.sv
package msm_pkg;

   // Latched operating mode of the memory model.
   typedef enum logic [1:0] {
      MODE_OPEN   = 2'd0,   // window still being observed
      MODE_SHARED = 2'd1,   // one image for all processors
      MODE_SPLIT  = 2'd2    // one private image per processor
   } mode_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/msm_bank.sv
module msm_bank #(
   parameter int BANKS = 1,
   parameter int WORDS = 2,
   parameter int DW    = 8,
   parameter int BW    = 1,
   parameter int AW    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          we,
   input  logic [BW-1:0] bank,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [BANKS][WORDS];
   logic [BW-1:0] sel;

   generate
      if (BANKS == 1) begin : g_single
         // single image: the processor index takes no part in the access
         assign sel = '0;
         logic unused_bank;
         assign unused_bank = ^bank;
      end else begin : g_multi
         assign sel = bank;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < BANKS; b++)
            for (int w = 0; w < WORDS; w++)
               mem[b][w] <= '0;
      end else if (en && we) begin
         mem[sel][addr] <= wdata;
      end
   end

   assign rdata = mem[sel][addr];

   // R6: a write lands in the selected copy and is visible next cycle
   p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && we) |=> (mem[$past(sel)][$past(addr)] == $past(wdata)));

endmodule

// File: rtl/msm_fifo.sv
module msm_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);

   localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNTW = $clog2(DEPTH + 1);
   localparam logic [PTRW-1:0] LASTP = PTRW'(DEPTH - 1);

   logic [W-1:0]    slots [DEPTH];
   logic [PTRW-1:0] wr_ptr, rd_ptr;
   logic [CNTW-1:0] count;

   function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
      return (p == LASTP) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= bump(wr_ptr);
         if (pop)  rd_ptr <= bump(rd_ptr);
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) slots[wr_ptr] <= din;
   end

   assign dout  = slots[rd_ptr];
   assign full  = (count == CNTW'(DEPTH));
   assign empty = (count == '0);

   // R9: the producer never writes into a full buffer
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/msm_mode_sync.sv
module msm_mode_sync
   import msm_pkg::*;
#(
   parameter int NUM_PROC = 3,
   parameter int NUM_ADDR = 2,
   parameter int PW       = 2,
   parameter int AW       = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  logic          is_write,
   input  logic [PW-1:0] proc,
   input  logic [AW-1:0] addr,
   output logic          decided,
   output logic          split
);

   localparam int PA   = NUM_PROC * NUM_ADDR;
   localparam int IW   = (PA > 1) ? $clog2(PA) : 1;
   localparam int CW   = $clog2(PA + 1);
   localparam logic [CW-1:0] LAST = CW'(PA - 1);

   mode_e           state;
   logic [CW-1:0]   cnt;
   logic [PA-1:0]   seen;
   logic [IW-1:0]   idx;

   assign idx = IW'(proc) * IW'(NUM_ADDR) + IW'(addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= MODE_OPEN;
         cnt   <= '0;
         seen  <= '0;
      end else if (acc && state == MODE_OPEN) begin
         cnt <= cnt + 1'b1;
         if (!is_write || seen[idx]) begin
            state <= MODE_SHARED;          // split outcome now impossible
         end else begin
            seen[idx] <= 1'b1;
            if (cnt == LAST) state <= MODE_SPLIT;
         end
      end
   end

   assign decided = (state != MODE_OPEN);
   assign split   = (state == MODE_SPLIT);

   // R10: a latched mode never moves again
   p_mode_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state != MODE_OPEN) |=> (state == $past(state)));
   // R2: the window never runs past its length while undecided
   p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_OPEN) |-> (cnt < CW'(PA)));

endmodule

// File: rtl/mode_switch_mem.sv
module mode_switch_mem
   import msm_pkg::*;
#(
   parameter int NUM_PROC = 3,
   parameter int NUM_ADDR = 2,
   parameter int DATA_W   = 8,
   parameter int PW       = idx_width(NUM_PROC),
   parameter int AW       = idx_width(NUM_ADDR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_write,
   input  logic [PW-1:0]     in_proc,
   input  logic [AW-1:0]     in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_write,
   output logic [PW-1:0]     out_proc,
   output logic [AW-1:0]     out_addr,
   output logic [DATA_W-1:0] out_data
);

   localparam int PA = NUM_PROC * NUM_ADDR;
   localparam int RW = 1 + PW + AW + DATA_W;

   generate
      if (NUM_PROC < 1 || NUM_ADDR < 1 || DATA_W < 1) begin : g_bad_size
         $error("mode_switch_mem: sizes must be positive");
      end
      if (PW < idx_width(NUM_PROC) || AW < idx_width(NUM_ADDR)) begin : g_bad_width
         $error("mode_switch_mem: index widths too narrow");
      end
   endgenerate

   logic              acc, pop, full, empty, decided, split;
   logic [DATA_W-1:0] sh_rd, pr_rd;
   logic [RW-1:0]     sh_resp, pr_resp, head;
   logic [2*RW-1:0]   pair_out;

   assign acc = in_valid && in_ready;

   msm_bank #(.BANKS(1), .WORDS(NUM_ADDR), .DW(DATA_W), .BW(PW), .AW(AW)) u_shared (
      .clk(clk), .rst_n(rst_n), .en(acc), .we(in_write), .bank(in_proc),
      .addr(in_addr), .wdata(in_data), .rdata(sh_rd));

   msm_bank #(.BANKS(NUM_PROC), .WORDS(NUM_ADDR), .DW(DATA_W), .BW(PW), .AW(AW)) u_private (
      .clk(clk), .rst_n(rst_n), .en(acc), .we(in_write), .bank(in_proc),
      .addr(in_addr), .wdata(in_data), .rdata(pr_rd));

   assign sh_resp = {in_write, in_proc, in_addr, in_write ? in_data : sh_rd};
   assign pr_resp = {in_write, in_proc, in_addr, in_write ? in_data : pr_rd};

   msm_mode_sync #(.NUM_PROC(NUM_PROC), .NUM_ADDR(NUM_ADDR), .PW(PW), .AW(AW)) u_sync (
      .clk(clk), .rst_n(rst_n), .acc(acc), .is_write(in_write), .proc(in_proc),
      .addr(in_addr), .decided(decided), .split(split));

   msm_fifo #(.W(2 * RW), .DEPTH(PA)) u_buf (
      .clk(clk), .rst_n(rst_n), .push(acc), .din({sh_resp, pr_resp}),
      .pop(pop), .dout(pair_out), .full(full), .empty(empty));

   assign in_ready  = !full;
   assign out_valid = decided && !empty;
   assign pop       = out_valid && out_ready;
   assign head      = split ? pair_out[RW-1:0] : pair_out[2*RW-1:RW];
   assign {out_write, out_proc, out_addr, out_data} = head;

   // input legality taken for granted by the model
   p_legal_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (int'(in_proc) < NUM_PROC && int'(in_addr) < NUM_ADDR));
   // R9: a stalled response holds its value
   p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable({out_write, out_proc, out_addr, out_data})));

endmodule

// File: tb/mode_switch_mem_test.sv
module mode_switch_mem_test;

   localparam int P  = 3;
   localparam int A  = 2;
   localparam int DW = 8;
   localparam int PW = 2;
   localparam int AW = 1;

   logic clk = 1'b0;
   logic rst_n;
   logic in_valid, in_ready, in_write, out_valid, out_ready, out_write;
   logic [PW-1:0] in_proc, out_proc;
   logic [AW-1:0] in_addr, out_addr;
   logic [DW-1:0] in_data, out_data;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   mode_switch_mem #(.NUM_PROC(P), .NUM_ADDR(A), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_write(in_write), .in_proc(in_proc), .in_addr(in_addr), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
      .out_proc(out_proc), .out_addr(out_addr), .out_data(out_data));

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      in_write = 1'b0; in_proc = '0; in_addr = '0; in_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input bit w, input int p, input int a, input int d);
      int t = 0;
      in_valid = 1'b1; in_write = w;
      in_proc = PW'(p); in_addr = AW'(a); in_data = DW'(d);
      while (!in_ready && t < 50) begin @(negedge clk); t++; end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // packed expected response: {write, proc, addr, data}
   task automatic take(input bit w, input int p, input int a, input int d, input string req);
      int t = 0;
      int act, exp;
      out_ready = 1'b1;
      while (!out_valid && t < 50) begin @(negedge clk); t++; end
      act = {out_valid, out_write, 6'(out_proc), 4'(out_addr), out_data};
      exp = {1'b1, w, 6'(p), 4'(a), 8'(d)};
      check(act == exp, req, act, exp);
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check(out_valid == 1'b0, "R1", out_valid, 0);
      check(in_ready == 1'b1, "R1", in_ready, 1);
   endtask

   task automatic t_early_read();   // R3 R4 R5 R7
      do_reset();
      send(1, 0, 1, 9);
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R4", out_valid, 0);
      send(0, 2, 1, 0);
      check(out_valid == 1'b1, "R3", out_valid, 1);
      take(1, 0, 1, 9, "R7");
      take(0, 2, 1, 9, "R5");
   endtask

   task automatic t_dup_write();    // R3 R5
      do_reset();
      send(1, 1, 0, 5);
      send(1, 1, 0, 6);
      check(out_valid == 1'b1, "R3", out_valid, 1);
      take(1, 1, 0, 5, "R8");
      take(1, 1, 0, 6, "R8");
      send(0, 0, 0, 0);
      take(0, 0, 0, 6, "R5");
   endtask

   task automatic t_split();        // R2 R4 R6 R10 R11
      do_reset();
      send(1, 2, 1, 34);
      send(1, 0, 0, 1);
      send(1, 1, 1, 18);
      send(1, 2, 0, 33);
      send(1, 0, 1, 2);
      check(out_valid == 1'b0, "R4", out_valid, 0);
      send(1, 1, 0, 17);
      check(out_valid == 1'b1, "R2", out_valid, 1);
      take(1, 2, 1, 34, "R8");
      take(1, 0, 0, 1, "R8");
      take(1, 1, 1, 18, "R8");
      take(1, 2, 0, 33, "R8");
      take(1, 0, 1, 2, "R8");
      take(1, 1, 0, 17, "R8");
      send(0, 1, 0, 0); take(0, 1, 0, 17, "R11");
      send(0, 2, 0, 0); take(0, 2, 0, 33, "R6");
      send(0, 0, 1, 0); take(0, 0, 1, 2, "R6");
      send(1, 0, 0, 77); take(1, 0, 0, 77, "R7");
      send(0, 1, 0, 0); take(0, 1, 0, 17, "R10");
      send(0, 0, 0, 0); take(0, 0, 0, 77, "R6");
   endtask

   task automatic t_backpressure(); // R1 R8 R9
      do_reset();
      send(0, 0, 0, 0);
      send(1, 0, 1, 3);
      send(1, 1, 0, 4);
      send(1, 2, 1, 5);
      send(1, 1, 1, 6);
      send(1, 0, 0, 7);
      check(in_ready == 1'b0, "R9", in_ready, 0);
      repeat (3) @(negedge clk);
      check(out_valid == 1'b1, "R9", out_valid, 1);
      take(0, 0, 0, 0, "R1");
      check(in_ready == 1'b1, "R9", in_ready, 1);
      take(1, 0, 1, 3, "R8");
      take(1, 1, 0, 4, "R8");
      take(1, 2, 1, 5, "R8");
      take(1, 1, 1, 6, "R8");
      take(1, 0, 0, 7, "R8");
      send(0, 2, 1, 0);
      take(0, 2, 1, 6, "R5");
   endtask

   initial begin
      t_reset();
      t_early_read();
      t_dup_write();
      t_split();
      t_backpressure();
      summary();
      $finish;
   end

endmodule